// File: doc/BRIEF.md
# Clock-Domain Bridge for a Slow-Clocked 8-bit Timer

This block connects a bus on a fast system clock to an 8-bit up-counter that runs from a slow, unrelated crystal clock of about 32 kHz. Software writes three timer registers from the system side: a control register, the counter and a compare value. Each accepted write is held on the system side and handed to the timer domain with a toggle handshake. A per-register busy flag stays up until the timer domain has taken the value and the return toggle has been synchronized back. A write to a register that is still busy is dropped, and a sticky error bit records the drop.

The system side never samples the live counter. Each rising timer-clock edge flips a toggle, and each flip causes the system side to copy the counter into a read-back register. When the system clock has been stopped, the read-back register keeps its old value until the system side sees a new timer edge. Each timer edge at which the running counter equals the compare value sends an event across to the system side. The event appears there as a one-cycle interrupt pulse and as a sticky flag that is cleared by writing one to it. Compare matching is blocked on any timer edge at which a counter or compare write is being applied.

The timer period must be longer than four system-clock periods. With that margin the counter bus is stable whenever the system side copies it.

Top module: `async_timer_bridge`

## Requirements
- R1: After reset, every busy bit, the error bit, the read-back counter, the interrupt pulse and the sticky flag are all zero.
- R2: A write with `wr_sel` 0 (control), 1 (counter) or 2 (compare) to a register that is not busy sets that register's busy bit in the next system cycle. The bit returns to zero once the value has reached the timer domain and the acknowledgement has come back.
- R3: A write to a register whose busy bit is set is dropped. The register keeps the earlier value, and `wr_err` goes to one and stays there until reset.
- R4: While control bit 0 (run) is one, the counter goes up by one on each timer edge and wraps from 255 to 0. While run is zero, the counter holds its value.
- R5: A counter write loads the written value. When the counter is stopped and the counter busy bit has cleared, `cnt_rd` equals the written value.
- R6: `cnt_rd` changes only when the system side sees a new timer edge. When the busy bit of any write clears, `cnt_rd` already holds a value taken at or after the timer edge that applied that write.
- R7: A timer edge with run set and counter equal to compare produces exactly one `match_irq` pulse, one system cycle long. In the cycle of that pulse, `cnt_rd` already shows the compare value plus one.
- R8: `match_flag` sets together with `match_irq`. It stays set until `flag_clr` is driven high, and it clears in the cycle after that. If a new event arrives in the same cycle as `flag_clr`, the set wins.
- R9: No match event is raised on a timer edge at which a counter or compare write is applied, even if the old counter equals the old compare value.
- R10: If the system clock stops for an even number of timer edges, then after it restarts `cnt_rd` returns the value from before the stop until the next timer edge has been synchronized.
- R11: A write with `wr_sel` 3 has no effect: no busy bit rises and `wr_err` does not change.
- R12: While run is zero, equal counter and compare values raise no match event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | System-domain synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 control, 1 counter, 2 compare, 3 none |
| wr_data | input | 8 | Write data; for control, only bit 0 (run) is kept |
| flag_clr | input | 1 | Write-one clear of the sticky match flag |
| busy | output | 3 | Per-register busy bits, indexed as `wr_sel` |
| wr_err | output | 1 | Sticky bit: a write to a busy register was dropped |
| cnt_rd | output | 8 | Counter copy refreshed on timer edges |
| match_irq | output | 1 | One-cycle compare interrupt pulse |
| match_flag | output | 1 | Sticky compare flag |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst | input | 1 | Timer-domain synchronous reset, active high |

## Verification
The assertions check the following on every clock of their own domain: busy bits rise only on a write strobe, dropped writes mark the error bit, the error bit never falls, the counter steps by exactly one while running, the match toggle does not move while a write is being applied or while the counter is stopped, and interrupt pulses last one cycle and are tied to the flag. Some properties depend on the phase between the two clocks, and only the bench's scenarios can show them. These are the suppression of a match that a pending counter write hides, the stale read-back after a system-clock pause, the compare value plus one seen at the interrupt, and the end-to-end load and wrap values.

// File: rtl/atb_pkg.sv
package atb_pkg;

    localparam int DATA_W  = 8;
    localparam int RUN_BIT = 0;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CMP  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int NUM_REGS = 3;
    localparam int NUM_DATA = 2;

    function automatic logic sel_valid(reg_sel_e s);
        return s != SEL_NONE;
    endfunction

endpackage

// File: rtl/atb_sync2.sv
module atb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/atb_wr_chan.sv
module atb_wr_chan #(
    parameter int W = 8
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    output logic         busy,
    output logic         rej,
    input  logic         tmr_clk,
    input  logic         tmr_rst,
    output logic         upd,
    output logic [W-1:0] upd_data
);
    logic         req_t;
    logic         ack_s;
    logic         ack_d;
    logic [W-1:0] hold;
    logic         req_s;
    logic         req_d;

    assign busy = req_t ^ ack_d;
    assign rej  = wr_hit & busy;

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            req_t <= 1'b0;
            ack_d <= 1'b0;
            hold  <= '0;
        end else begin
            ack_d <= ack_s;
            if (wr_hit && !busy) begin
                req_t <= ~req_t;
                hold  <= wr_data;
            end
        end
    end

    atb_sync2 #(.W(1)) u_ack_sync (
        .clk (sys_clk),
        .rst (sys_rst),
        .d   (req_d),
        .q   (ack_s)
    );

    atb_sync2 #(.W(1)) u_req_sync (
        .clk (tmr_clk),
        .rst (tmr_rst),
        .d   (req_t),
        .q   (req_s)
    );

    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) req_d <= 1'b0;
        else         req_d <= req_s;
    end

    assign upd      = req_s ^ req_d;
    assign upd_data = hold;

    // R2
    busy_rise_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        $rose(busy) |-> $past(wr_hit));

    // R3
    drop_keeps_hold_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (wr_hit && busy) |=> $stable(hold));

endmodule

// File: rtl/atb_tmr_core.sv
module atb_tmr_core #(
    parameter int W = 8
) (
    input  logic         tmr_clk,
    input  logic         tmr_rst,
    input  logic         upd_ctrl,
    input  logic         run_d,
    input  logic         upd_cnt,
    input  logic [W-1:0] cnt_d,
    input  logic         upd_cmp,
    input  logic [W-1:0] cmp_d,
    output logic [W-1:0] cnt,
    output logic         match_tog,
    output logic         snap_tog
);
    logic         run;
    logic [W-1:0] cmp_q;
    logic         wr_block;
    logic         hit;

    assign wr_block = upd_cnt | upd_cmp;
    assign hit      = run && (cnt == cmp_q) && !wr_block;

    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) begin
            run       <= 1'b0;
            cmp_q     <= '0;
            cnt       <= '0;
            match_tog <= 1'b0;
            snap_tog  <= 1'b0;
        end else begin
            snap_tog <= ~snap_tog;
            if (hit)      match_tog <= ~match_tog;
            if (upd_ctrl) run       <= run_d;
            if (upd_cmp)  cmp_q     <= cmp_d;
            if (upd_cnt)  cnt       <= cnt_d;
            else if (run) cnt       <= cnt + W'(1);
        end
    end

    // R4
    count_step_chk: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        (run && !upd_cnt) |=> (cnt == $past(cnt) + W'(1)));

    // R4
    count_hold_chk: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        (!run && !upd_cnt) |=> $stable(cnt));

    // R9
    pending_no_match_chk: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        (upd_cnt || upd_cmp) |=> $stable(match_tog));

    // R12
    stopped_no_match_chk: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        !run |=> $stable(match_tog));

endmodule

// File: rtl/atb_sys_rx.sv
module atb_sys_rx #(
    parameter int W = 8
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  logic [W-1:0] cnt_live,
    input  logic         snap_tog,
    input  logic         match_tog,
    input  logic         flag_clr,
    output logic [W-1:0] cnt_rd,
    output logic         irq,
    output logic         flag
);
    logic snap_s;
    logic snap_d;
    logic mt_s;
    logic mt_d;
    logic fresh;
    logic ev;

    atb_sync2 #(.W(1)) u_snap_sync (
        .clk (sys_clk),
        .rst (sys_rst),
        .d   (snap_tog),
        .q   (snap_s)
    );

    atb_sync2 #(.W(1)) u_match_sync (
        .clk (sys_clk),
        .rst (sys_rst),
        .d   (match_tog),
        .q   (mt_s)
    );

    assign fresh = snap_s ^ snap_d;
    assign ev    = mt_s ^ mt_d;

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            snap_d <= 1'b0;
            mt_d   <= 1'b0;
            cnt_rd <= '0;
            irq    <= 1'b0;
            flag   <= 1'b0;
        end else begin
            snap_d <= snap_s;
            mt_d   <= mt_s;
            irq    <= ev;
            if (fresh) cnt_rd <= cnt_live;
            if (ev)            flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    // R7
    irq_single_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        irq |=> !irq);

    // R8
    flag_sticky_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (flag && !flag_clr) |=> flag);

    // R8
    flag_rise_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        $rose(flag) |-> irq);

endmodule

// File: rtl/async_timer_bridge.sv
module async_timer_bridge
    import atb_pkg::*;
#(
    parameter int W = atb_pkg::DATA_W
) (
    input  logic                sys_clk,
    input  logic                sys_rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [W-1:0]        wr_data,
    input  logic                flag_clr,
    output logic [NUM_REGS-1:0] busy,
    output logic                wr_err,
    output logic [W-1:0]        cnt_rd,
    output logic                match_irq,
    output logic                match_flag,
    input  logic                tmr_clk,
    input  logic                tmr_rst
);
    reg_sel_e            sel;
    logic                wr_ok;
    logic [NUM_REGS-1:0] rej;
    logic                ctrl_upd;
    logic                ctrl_val;
    logic                dat_upd [NUM_DATA];
    logic [W-1:0]        dat_val [NUM_DATA];
    logic [W-1:0]        cnt_live;
    logic                match_tog;
    logic                snap_tog;

    assign sel   = reg_sel_e'(wr_sel);
    assign wr_ok = wr_en && sel_valid(sel);

    atb_wr_chan #(.W(1)) u_ctrl_chan (
        .sys_clk  (sys_clk),
        .sys_rst  (sys_rst),
        .wr_hit   (wr_ok && (sel == SEL_CTRL)),
        .wr_data  (wr_data[RUN_BIT]),
        .busy     (busy[int'(SEL_CTRL)]),
        .rej      (rej[int'(SEL_CTRL)]),
        .tmr_clk  (tmr_clk),
        .tmr_rst  (tmr_rst),
        .upd      (ctrl_upd),
        .upd_data (ctrl_val)
    );

    for (genvar g = 0; g < NUM_DATA; g++) begin : g_data_chan
        localparam reg_sel_e CH_SEL = reg_sel_e'(2'(g + 1));
        atb_wr_chan #(.W(W)) u_chan (
            .sys_clk  (sys_clk),
            .sys_rst  (sys_rst),
            .wr_hit   (wr_ok && (sel == CH_SEL)),
            .wr_data  (wr_data),
            .busy     (busy[g + 1]),
            .rej      (rej[g + 1]),
            .tmr_clk  (tmr_clk),
            .tmr_rst  (tmr_rst),
            .upd      (dat_upd[g]),
            .upd_data (dat_val[g])
        );
    end

    always_ff @(posedge sys_clk) begin
        if (sys_rst)   wr_err <= 1'b0;
        else if (|rej) wr_err <= 1'b1;
    end

    atb_tmr_core #(.W(W)) u_core (
        .tmr_clk   (tmr_clk),
        .tmr_rst   (tmr_rst),
        .upd_ctrl  (ctrl_upd),
        .run_d     (ctrl_val),
        .upd_cnt   (dat_upd[int'(SEL_CNT) - 1]),
        .cnt_d     (dat_val[int'(SEL_CNT) - 1]),
        .upd_cmp   (dat_upd[int'(SEL_CMP) - 1]),
        .cmp_d     (dat_val[int'(SEL_CMP) - 1]),
        .cnt       (cnt_live),
        .match_tog (match_tog),
        .snap_tog  (snap_tog)
    );

    atb_sys_rx #(.W(W)) u_rx (
        .sys_clk   (sys_clk),
        .sys_rst   (sys_rst),
        .cnt_live  (cnt_live),
        .snap_tog  (snap_tog),
        .match_tog (match_tog),
        .flag_clr  (flag_clr),
        .cnt_rd    (cnt_rd),
        .irq       (match_irq),
        .flag      (match_flag)
    );

    // R3
    err_sticky_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        wr_err |=> wr_err);

    // R3
    err_on_drop_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (wr_ok && busy[wr_sel]) |=> wr_err);

    // R11
    none_sel_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (wr_en && sel == SEL_NONE) |=> ((busy & ~$past(busy)) == '0));

endmodule

// File: tb/async_timer_bridge_test.sv
module async_timer_bridge_test;
    localparam int SYS_PERIOD = 10;
    localparam int TMR_PERIOD = 70;
    localparam int TMR_CYC    = TMR_PERIOD / SYS_PERIOD;
    localparam logic [1:0] S_CTRL = 2'd0;
    localparam logic [1:0] S_CNT  = 2'd1;
    localparam logic [1:0] S_CMP  = 2'd2;
    localparam logic [1:0] S_NONE = 2'd3;

    logic       sys_raw = 1'b0;
    logic       sys_run = 1'b1;
    logic       sys_clk;
    logic       tmr_clk = 1'b0;
    logic       sys_rst = 1'b1;
    logic       tmr_rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       flag_clr = 1'b0;
    logic [2:0] busy;
    logic       wr_err;
    logic [7:0] cnt_rd;
    logic       match_irq;
    logic       match_flag;

    int   checks = 0;
    int   errors = 0;
    int   irq_n = 0;
    logic [7:0] irq_cnt = 8'd0;
    logic mon = 1'b0;
    logic [7:0] prev = 8'd0;
    logic wrap_seen = 1'b0;

    assign sys_clk = sys_raw & sys_run;

    always #(SYS_PERIOD/2) sys_raw = ~sys_raw;
    initial begin
        #3;
        forever #(TMR_PERIOD/2) tmr_clk = ~tmr_clk;
    end

    async_timer_bridge uut (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_clr(flag_clr), .busy(busy), .wr_err(wr_err),
        .cnt_rd(cnt_rd), .match_irq(match_irq), .match_flag(match_flag),
        .tmr_clk(tmr_clk), .tmr_rst(tmr_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] plus(input logic [7:0] v, input int n);
        return 8'(int'(v) + n);
    endfunction

    always @(negedge sys_clk) begin
        if (match_irq) begin
            irq_n++;
            irq_cnt = cnt_rd;
        end
        if (mon && cnt_rd != prev) begin
            // R4: each refresh steps by one, modulo 256
            chk(cnt_rd == plus(prev, 1), "R4 step", cnt_rd, plus(prev, 1));
            if (prev == 8'd255 && cnt_rd == 8'd0) wrap_seen = 1'b1;
            prev = cnt_rd;
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge sys_clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge sys_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy != 3'b000 && n < 100) begin
            @(negedge sys_clk);
            n++;
        end
        chk(busy == 3'b000, req, busy, 0);
    endtask

    task automatic wrw(input logic [1:0] s, input logic [7:0] d);
        wr(s, d);
        chk(busy[s] == 1'b1, "R2 busy set", busy[s], 1);
        wait_idle("R2 busy clear");
        @(negedge sys_clk);
    endtask

    task automatic tmr_wait(input int n);
        repeat (n * TMR_CYC) @(negedge sys_clk);
    endtask

    initial begin
        #(SYS_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] k;
        int n0;
        int seed;
        seed = $urandom(32'd2718);

        repeat (4 * TMR_CYC) @(negedge sys_clk);
        sys_rst = 1'b0;
        tmr_rst = 1'b0;
        @(negedge sys_clk);

        // R1 reset state
        chk(busy == 3'b000 && !wr_err, "R1 busy/err", {busy, wr_err}, 0);
        chk(cnt_rd == 8'd0, "R1 cnt_rd", cnt_rd, 0);
        chk(!match_irq && !match_flag, "R1 irq/flag", {match_irq, match_flag}, 0);

        // R11 write to unused select
        wr(S_NONE, 8'h55);
        chk(busy == 3'b000, "R11 busy", busy, 0);
        @(negedge sys_clk);
        chk(!wr_err, "R11 err", wr_err, 0);

        // R5 random loads with the counter stopped
        for (int i = 0; i < 8; i++) begin
            v = 8'($urandom);
            wrw(S_CNT, v);
            @(negedge sys_clk);
            chk(cnt_rd == v, "R5 load", cnt_rd, v);
        end

        // R6 control write then busy clear gives a fresh copy
        wrw(S_CNT, 8'h3C);
        wrw(S_CTRL, 8'h00);
        chk(cnt_rd == 8'h3C, "R6 fresh", cnt_rd, 8'h3C);

        // R3 write while busy is dropped
        wr(S_CNT, 8'h33);
        wr(S_CNT, 8'hCC);
        chk(wr_err == 1'b1, "R3 err", wr_err, 1);
        wait_idle("R2 busy clear");
        @(negedge sys_clk);
        chk(cnt_rd == 8'h33, "R3 kept", cnt_rd, 8'h33);

        // R4 wrap
        wrw(S_CNT, 8'd250);
        wrw(S_CMP, 8'd100);
        wrw(S_CTRL, 8'h01);
        prev = cnt_rd; wrap_seen = 1'b0; mon = 1'b1;
        tmr_wait(12);
        mon = 1'b0;
        chk(wrap_seen, "R4 wrap", wrap_seen, 1);

        // R7 / R8 match with random compare values
        for (int i = 0; i < 3; i++) begin
            k = 8'($urandom_range(3, 250));
            wrw(S_CTRL, 8'h00);
            @(negedge sys_clk); flag_clr = 1'b1;
            @(negedge sys_clk); flag_clr = 1'b0;
            wrw(S_CMP, k);
            wrw(S_CNT, plus(k, -3));
            n0 = irq_n;
            wrw(S_CTRL, 8'h01);
            prev = cnt_rd; mon = 1'b1;
            tmr_wait(10);
            mon = 1'b0;
            chk(irq_n == n0 + 1, "R7 one pulse", irq_n - n0, 1);
            chk(irq_cnt == plus(k, 1), "R7 advanced", irq_cnt, plus(k, 1));
            chk(match_flag == 1'b1, "R8 flag set", match_flag, 1);
            @(negedge sys_clk); flag_clr = 1'b1;
            @(negedge sys_clk); flag_clr = 1'b0;
            chk(match_flag == 1'b0, "R8 flag clear", match_flag, 0);
        end

        // R12 stopped counter equal to compare
        wrw(S_CTRL, 8'h00);
        wrw(S_CMP, 8'd77);
        wrw(S_CNT, 8'd77);
        n0 = irq_n;
        tmr_wait(10);
        chk(irq_n == n0 && !match_flag, "R12 no match", irq_n - n0, 0);

        // R9 match hidden by a pending counter write
        wrw(S_CMP, 8'd100);
        wrw(S_CNT, 8'd90);
        wrw(S_CTRL, 8'h01);
        begin
            int n = 0;
            while (cnt_rd != 8'd98 && n < 40 * TMR_CYC) begin
                @(negedge sys_clk);
                n++;
            end
        end
        n0 = irq_n;
        wr(S_CNT, 8'd20);
        wait_idle("R2 busy clear");
        tmr_wait(15);
        chk(irq_n == n0, "R9 suppressed", irq_n - n0, 0);
        chk(!match_flag, "R9 flag", match_flag, 0);

        // R10 stale read after a system clock pause of four timer edges
        v = cnt_rd;
        begin
            int n = 0;
            while (cnt_rd == v && n < 3 * TMR_CYC) begin
                @(negedge sys_clk);
                n++;
            end
        end
        v = cnt_rd;
        sys_run = 1'b0;
        #(4 * TMR_PERIOD);
        sys_run = 1'b1;
        repeat (3) @(negedge sys_clk);
        chk(cnt_rd == v, "R10 stale", cnt_rd, v);
        repeat (6) @(negedge sys_clk);
        chk(cnt_rd == plus(v, 5), "R10 refresh", cnt_rd, plus(v, 5));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule